// File: doc/BRIEF.md
# Configurable Output Logic Cell

This block is the output stage that sits behind one OR-sum of a sum-of-products programmable logic array. A two-bit configuration chooses whether the sum reaches the pin through a D flip-flop or directly, and whether the pin value is inverted. The same configuration decides what goes back into the array as feedback. The cell shares a clock, an asynchronous clear and a synchronous set with its neighbours. A test load path lets a tester write the stored bit on a clock edge.

Configuration bits follow the convention of non-volatile programming cells: an unprogrammed (erased) bit reads as 1 and a programmed bit reads as 0. The cell carries no data stream. It has no valid/ready handshake and no back-pressure: every input is sampled each cycle, and both outputs are plain levels that are valid at all times. The asynchronous clear also serves as the power-up initialisation: the bench holds it from time zero.

Top module: `pal_out_cell`

## Requirements
- R1: With cfg_s1=0 and cfg_s0=0 the stored bit is captured from or_sum at each rising clock edge, and pin_out is its inverse.
- R2: With cfg_s1=0 and cfg_s0=1, pin_out equals the stored bit, which is captured from or_sum at each rising clock edge.
- R3: With cfg_s1=1 and cfg_s0=0, pin_out is the inverse of or_sum in the same cycle, with no clock edge between them.
- R4: With cfg_s1=1 and cfg_s0=1, pin_out equals or_sum in the same cycle.
- R5: Asserting arst (active high) clears the stored bit at once, with no clock edge. The bit stays 0 for as long as arst is high.
- R6: When sync_set is high at a rising edge, and arst and load_en are low, the stored bit becomes 1. Raising sync_set between edges has no effect on the stored bit.
- R7: When arst and sync_set are both high, the stored bit is 0.
- R8: When load_en is high at a rising edge, the stored bit takes load_val, whatever or_sum and sync_set are. While arst is high, load_en has no effect and the bit stays 0.
- R9: In the registered modes (cfg_s1=0), fb_out is the true stored bit. In the combinatorial modes (cfg_s1=1), fb_out equals pin_out.
- R10: After reset the stored bit is 0. In mode cfg_s1=0, cfg_s0=0, pin_out is therefore 1 and fb_out is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, rising edge active |
| arst | input | 1 | Global asynchronous clear and power-up reset, active high |
| sync_set | input | 1 | Global set, takes effect on a rising edge |
| or_sum | input | 1 | OR-sum of the product terms for this cell |
| cfg_s1 | input | 1 | Path select: 0 registered, 1 combinatorial (erased reads 1) |
| cfg_s0 | input | 1 | Polarity select: 0 active low, 1 active high (erased reads 1) |
| load_en | input | 1 | Test load enable for the stored bit |
| load_val | input | 1 | Value written by a test load |
| pin_out | output | 1 | Value towards the pin driver |
| fb_out | output | 1 | Value fed back into the array |

## Verification
The cell has no parameters, so the bench builds it as it stands. All four configuration codes are therefore within reach, including switches between them while the stored bit keeps tracking the sum. The priority order at an edge (clear, then load, then set, then data) is exercised by driving all four inputs together. Two checks are made between clock edges: one shows that the clear acts at once, and one shows that a mid-cycle set changes nothing.

// File: rtl/pal_cell_pkg.sv
package pal_cell_pkg;

  // Output modes, keyed by {s1, s0}; a 1 is an erased configuration bit
  typedef enum logic [1:0] {
    MODE_REG_LOW   = 2'b00,
    MODE_REG_HIGH  = 2'b01,
    MODE_COMB_LOW  = 2'b10,
    MODE_COMB_HIGH = 2'b11
  } cell_mode_e;

  typedef struct packed {
    logic registered;   // route through the flip-flop
    logic active_high;  // no inversion at the pin
  } path_sel_t;

endpackage

// File: rtl/pal_cfg_decode.sv
module pal_cfg_decode
  import pal_cell_pkg::*;
(
  input  logic      cfg_s1,
  input  logic      cfg_s0,
  output path_sel_t sel
);

  cell_mode_e mode;

  always_comb begin
    mode = cell_mode_e'({cfg_s1, cfg_s0});
    unique case (mode)
      MODE_REG_LOW:   sel = '{registered: 1'b1, active_high: 1'b0};
      MODE_REG_HIGH:  sel = '{registered: 1'b1, active_high: 1'b1};
      MODE_COMB_LOW:  sel = '{registered: 1'b0, active_high: 1'b0};
      MODE_COMB_HIGH: sel = '{registered: 1'b0, active_high: 1'b1};
      default:        sel = '{registered: 1'b1, active_high: 1'b0};
    endcase
  end

endmodule

// File: rtl/pal_cell_reg.sv
module pal_cell_reg (
  input  logic clk,
  input  logic arst,
  input  logic sync_set,
  input  logic d,
  input  logic load_en,
  input  logic load_val,
  output logic q
);

  // Clear is asynchronous and beats everything; load beats set; set beats data
  always_ff @(posedge clk or posedge arst) begin
    if (arst)          q <= 1'b0;
    else if (load_en)  q <= load_val;
    else if (sync_set) q <= 1'b1;
    else               q <= d;
  end

  // R8: a test load forces the stored bit on the next edge
  a_r8_load_wins: assert property (@(posedge clk) disable iff (arst)
    load_en |=> q == $past(load_val));

  // R6: the set drives the bit to 1 on the edge when no load is present
  a_r6_set_on_edge: assert property (@(posedge clk) disable iff (arst)
    (sync_set && !load_en) |=> q);

  // R1: with no load or set, the bit follows the data input
  a_r1_capture: assert property (@(posedge clk) disable iff (arst)
    (!sync_set && !load_en) |=> q == $past(d));

endmodule

// File: rtl/pal_cell_outsel.sv
module pal_cell_outsel
  import pal_cell_pkg::*;
(
  input  path_sel_t sel,
  input  logic      q,
  input  logic      or_sum,
  output logic      pin_out,
  output logic      fb_out
);

  logic raw;

  always_comb begin
    raw     = sel.registered ? q : or_sum;
    pin_out = sel.active_high ? raw : ~raw;
    // Registered modes return the true stored bit; combinatorial ones the pin
    fb_out  = sel.registered ? q : pin_out;
  end

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
  import pal_cell_pkg::*;
(
  input  logic clk,
  input  logic arst,
  input  logic sync_set,
  input  logic or_sum,
  input  logic cfg_s1,
  input  logic cfg_s0,
  input  logic load_en,
  input  logic load_val,
  output logic pin_out,
  output logic fb_out
);

  path_sel_t sel;
  logic      q;

  pal_cfg_decode u_dec (
    .cfg_s1 (cfg_s1),
    .cfg_s0 (cfg_s0),
    .sel    (sel)
  );

  pal_cell_reg u_reg (
    .clk      (clk),
    .arst     (arst),
    .sync_set (sync_set),
    .d        (or_sum),
    .load_en  (load_en),
    .load_val (load_val),
    .q        (q)
  );

  pal_cell_outsel u_out (
    .sel     (sel),
    .q       (q),
    .or_sum  (or_sum),
    .pin_out (pin_out),
    .fb_out  (fb_out)
  );

  // R2/R9: registered active-high, the pin and feedback agree
  a_r2_reg_high_match: assert property (@(posedge clk) disable iff (arst)
    (!cfg_s1 && cfg_s0) |-> pin_out == fb_out);

  // R1/R9: registered active-low, the pin is the complement of the feedback
  a_r1_reg_low_invert: assert property (@(posedge clk) disable iff (arst)
    (!cfg_s1 && !cfg_s0) |-> pin_out != fb_out);

  // R4: combinatorial active-high passes the sum straight through
  a_r4_comb_high: assert property (@(posedge clk) disable iff (arst)
    (cfg_s1 && cfg_s0) |-> pin_out == or_sum);

  // R3: combinatorial active-low inverts the sum
  a_r3_comb_low: assert property (@(posedge clk) disable iff (arst)
    (cfg_s1 && !cfg_s0) |-> pin_out != or_sum);

endmodule

// File: tb/sim_pal_out_cell.sv
module sim_pal_out_cell;

  logic clk = 1'b0;
  logic arst, sync_set, or_sum, cfg_s1, cfg_s0, load_en, load_val;
  logic pin_out, fb_out;

  always #4 clk = ~clk;  // 125 MHz

  pal_out_cell u0 (
    .clk(clk), .arst(arst), .sync_set(sync_set), .or_sum(or_sum),
    .cfg_s1(cfg_s1), .cfg_s0(cfg_s0), .load_en(load_en), .load_val(load_val),
    .pin_out(pin_out), .fb_out(fb_out)
  );

  typedef struct {
    logic  pin;
    logic  fb;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  logic q_model  = 1'b0;
  bit   finished = 1'b0;

  task automatic check(input logic act, input logic exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected outputs
  task automatic step(input logic sum, input logic set, input logic ld,
                      input logic lv, input logic s1, input logic s0,
                      input logic ar, input string tag);
    exp_t e;
    logic pin_m;
    @(negedge clk);
    or_sum = sum; sync_set = set; load_en = ld; load_val = lv;
    cfg_s1 = s1; cfg_s0 = s0; arst = ar;
    if (ar)       q_model = 1'b0;
    else if (ld)  q_model = lv;
    else if (set) q_model = 1'b1;
    else          q_model = sum;
    if (s1) pin_m = s0 ? sum : ~sum;
    else    pin_m = s0 ? q_model : ~q_model;
    e.pin = pin_m;
    e.fb  = s1 ? pin_m : q_model;
    e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: after each edge, compares the outputs with the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        check(pin_out, e.pin, {e.tag, " pin_out"});
        check(fb_out,  e.fb,  {e.tag, " fb_out"});
      end
    end
  end

  initial begin
    arst = 1'b1; sync_set = 1'b0; or_sum = 1'b1; cfg_s1 = 1'b0; cfg_s0 = 1'b0;
    load_en = 1'b0; load_val = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(pin_out, 1'b1, "R10 reset pin_out");
    check(fb_out,  1'b0, "R10 reset fb_out");

    // R2: registered active-high
    step(1, 0, 0, 0, 0, 1, 0, "R2 reg-high sum1");
    step(0, 0, 0, 0, 0, 1, 0, "R2 reg-high sum0");
    step(1, 0, 0, 0, 0, 1, 0, "R2 reg-high sum1 again");
    // R1: registered active-low
    step(1, 0, 0, 0, 0, 0, 0, "R1 reg-low sum1");
    step(0, 0, 0, 0, 0, 0, 0, "R1 reg-low sum0");
    // R4 and R9: combinatorial active-high
    step(1, 0, 0, 0, 1, 1, 0, "R4 comb-high sum1");
    step(0, 0, 0, 0, 1, 1, 0, "R4 comb-high sum0");
    // R3 and R9: combinatorial active-low
    step(1, 0, 0, 0, 1, 0, 0, "R3 comb-low sum1");
    step(0, 0, 0, 0, 1, 0, 0, "R3 comb-low sum0");
    // R9: back to registered, feedback is the true bit
    step(1, 0, 0, 0, 0, 0, 0, "R9 reg-low fb true");
    step(0, 0, 0, 0, 0, 1, 0, "R9 reg-high fb true");

    // R6: a mid-cycle set leaves the bit alone
    @(negedge clk);
    #1 sync_set = 1'b1;
    #1 check(fb_out, 1'b0, "R6 set between edges");
    sync_set = 1'b0;
    step(0, 1, 0, 0, 0, 1, 0, "R6 set at edge");

    // R7: clear beats set
    step(0, 1, 0, 0, 0, 1, 1, "R7 clear and set");
    step(0, 1, 0, 0, 0, 1, 0, "R7 set after clear");

    // R5: the clear acts between edges
    @(negedge clk);
    #1 arst = 1'b1;
    #1 check(fb_out, 1'b0, "R5 async clear fb_out");
    check(pin_out, 1'b0, "R5 async clear pin_out");
    q_model = 1'b0;
    step(1, 0, 0, 0, 0, 1, 1, "R5 clear held over edge");

    // R8: load beats data and set, not clear
    step(1, 1, 1, 0, 0, 1, 0, "R8 load 0 over sum and set");
    step(0, 0, 1, 1, 0, 1, 0, "R8 load 1 over sum");
    step(1, 1, 1, 1, 0, 1, 1, "R8 load ignored under clear");
    step(0, 0, 0, 0, 0, 0, 0, "R10 reg-low after clear");

    repeat (3) @(posedge clk);
    #3;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule